// File: doc/BRIEF.md
# Group Interrupt Presenter with Backlog

This block presents interrupts to a group of hardware threads. Each incoming request carries a priority of a few bits and is aimed either at one named thread or at the whole group. For every thread the block keeps three things: a current priority threshold, a notification status byte, and the priority of the interrupt that is presented to it. A smaller priority number is more favoured. A thread accepts an interrupt only when the interrupt's priority is numerically below the thread's threshold. A threshold of 0xFF accepts every priority.

A group request goes to exactly one thread that can accept it. When no thread can accept it, the block does not raise any notification. It records the request in a backlog that holds one bit per priority level. Every thread can see the most favoured backlogged level in its context word. The backlog is checked again on every cycle, so when software relaxes one thread's threshold, that thread picks up the held interrupt on the same clock edge. Software works through a per-thread port. It can read the context word, write the threshold, and do an acknowledge read. The acknowledge read returns the status and the interrupt's priority, and it raises the thread's threshold to that priority.

Top module: `grp_irq_presenter`

## Requirements
- R1: After reset every thread reads NSR 0x00, CPPR 0xFF and LSMFB 0xFF, and `notify` is all zero.
- R2: The context word is {NSR[31:24], CPPR[23:16], 8'h00, LSMFB[7:0]}. LSMFB is the numerically lowest set backlog level, or 0xFF when the backlog is empty.
- R3: An interrupt is presented to a thread only if its priority is numerically less than that thread's CPPR. A CPPR of 0xFF admits every priority.
- R4: A group interrupt is presented to exactly one thread, with NSR 0x82. When several idle threads admit it, the lowest-indexed one is chosen.
- R5: A thread-targeted interrupt is presented only to its target, with NSR 0x80. If that thread's CPPR blocks it, it stays pending for that thread alone. It never enters the group backlog, and it is presented once that thread's CPPR is relaxed.
- R6: A group interrupt that every thread blocks raises no NSR. Its level is set in the backlog and shows in every thread's LSMFB.
- R7: A CPPR write takes effect at the next clock edge, and CPPR reads back the written value. If the new value admits a backlogged level, NSR becomes 0x82 on that same edge.
- R8: An acknowledge read of a thread with a presented interrupt returns {NSR, 8-bit priority}. At the next edge NSR clears and CPPR becomes that priority.
- R9: If a CPPR write blocks the interrupt that is already presented to a thread, that thread's NSR clears and the interrupt goes back to pending. A group interrupt returns to the backlog and may be given to another idle thread that admits it on the same edge.
- R10: An acknowledge read with no interrupt presented returns {0x00, CPPR} and changes no state.
- R11: When several backlog levels are set, the most favoured admissible level is presented first, and LSMFB then moves to the next set level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_group | input | 1 | 1: request targets the group, 0: one thread |
| irq_thread | input | TW | Target thread for a thread request |
| irq_prio | input | PW | Request priority |
| cppr_we | input | 1 | CPPR write strobe |
| cppr_thread | input | TW | Thread whose CPPR is written |
| cppr_data | input | 8 | New CPPR value |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_thread | input | TW | Thread being acknowledged |
| ack_data | output | 16 | Acknowledge result {NSR, CPPR/priority} |
| ctx_thread | input | TW | Thread whose context word is read |
| ctx_word | output | 32 | Context word of the selected thread |
| notify | output | NTHR | Per-thread interrupt line, high while NSR is non-zero |

## Verification
The bench targets the backlog path. It blocks every thread, checks that no NSR is raised while LSMFB shows the level, then relaxes one thread's CPPR and checks that the interrupt appears on that same edge. A design that only scanned the backlog when new requests arrived would leave the interrupt stranded. A design that presented one cycle late would fail that check. Further vectors cover these cases:
- Threshold equal to the priority. An off-by-one compare would present here.
- Several eligible threads. A wrong arbiter picks a thread other than the lowest index.
- A blocked thread-targeted request. A design that leaks it into the group backlog changes LSMFB or hands it to another thread.
- A CPPR write that blocks an already presented interrupt. The interrupt must move to a free thread, not vanish.

// File: rtl/grp_irq_presenter.sv
module grp_irq_presenter #(
  parameter int NTHR = 4,
  parameter int PW   = 3,
  parameter int TW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_valid,
  input  logic            irq_group,
  input  logic [TW-1:0]   irq_thread,
  input  logic [PW-1:0]   irq_prio,
  input  logic            cppr_we,
  input  logic [TW-1:0]   cppr_thread,
  input  logic [7:0]      cppr_data,
  input  logic            ack_req,
  input  logic [TW-1:0]   ack_thread,
  output logic [15:0]     ack_data,
  input  logic [TW-1:0]   ctx_thread,
  output logic [31:0]     ctx_word,
  output logic [NTHR-1:0] notify
);
  localparam int NLVL = 1 << PW;
  localparam logic [7:0] ST_THR = 8'h80;
  localparam logic [7:0] ST_GRP = 8'h82;

  function automatic logic [PW:0] low_set(input logic [NLVL-1:0] m);
    low_set = {1'b1, {PW{1'b0}}};
    for (int i = NLVL - 1; i >= 0; i--)
      if (m[i]) low_set = {1'b0, PW'(i)};
  endfunction

  logic [7:0]      nsr_q  [NTHR];
  logic [7:0]      cppr_q [NTHR];
  logic [PW-1:0]   pp_q   [NTHR];
  logic [NLVL-1:0] tp_q   [NTHR];
  logic [NLVL-1:0] bl_q;

  logic [7:0]      cppr_n [NTHR];
  logic [NLVL-1:0] tm     [NTHR];
  logic [PW:0]     tb     [NTHR];
  logic [NTHR-1:0] ack_now, wdraw, tk, gsel;
  logic [NLVL-1:0] gm;
  logic [PW:0]     gb, bl_low;

  always_comb begin
    logic found;
    gm = bl_q;
    if (irq_valid && irq_group) gm[irq_prio] = 1'b1;
    for (int t = 0; t < NTHR; t++) begin
      cppr_n[t]  = (cppr_we && cppr_thread == TW'(t)) ? cppr_data : cppr_q[t];
      ack_now[t] = ack_req && ack_thread == TW'(t) && nsr_q[t] != 8'h00;
      wdraw[t]   = nsr_q[t] != 8'h00 && !ack_now[t] && cppr_n[t] <= 8'(pp_q[t]);
      tm[t] = tp_q[t];
      if (irq_valid && !irq_group && irq_thread == TW'(t)) tm[t][irq_prio] = 1'b1;
      if (wdraw[t] && nsr_q[t] == ST_THR) tm[t][pp_q[t]] = 1'b1;
      if (wdraw[t] && nsr_q[t] == ST_GRP) gm[pp_q[t]] = 1'b1;
    end
    gb = low_set(gm);
    found = 1'b0;
    gsel = '0;
    for (int t = 0; t < NTHR; t++) begin
      tb[t] = low_set(tm[t]);
      tk[t] = nsr_q[t] == 8'h00 && !tb[t][PW] && 8'(tb[t][PW-1:0]) < cppr_n[t];
      if (tk[t]) tm[t][tb[t][PW-1:0]] = 1'b0;
      if (nsr_q[t] == 8'h00 && !tk[t] && !gb[PW] && 8'(gb[PW-1:0]) < cppr_n[t] && !found) begin
        gsel[t] = 1'b1;
        found = 1'b1;
      end
    end
    if (found) gm[gb[PW-1:0]] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_q <= '0;
      for (int t = 0; t < NTHR; t++) begin
        nsr_q[t] <= 8'h00; cppr_q[t] <= 8'hFF; pp_q[t] <= '0; tp_q[t] <= '0;
      end
    end else begin
      bl_q <= gm;
      for (int t = 0; t < NTHR; t++) begin
        tp_q[t] <= tm[t];
        if (ack_now[t]) begin
          nsr_q[t]  <= 8'h00;
          cppr_q[t] <= 8'(pp_q[t]);
        end else begin
          cppr_q[t] <= cppr_n[t];
          if (wdraw[t])     nsr_q[t] <= 8'h00;
          else if (tk[t])   begin nsr_q[t] <= ST_THR; pp_q[t] <= tb[t][PW-1:0]; end
          else if (gsel[t]) begin nsr_q[t] <= ST_GRP; pp_q[t] <= gb[PW-1:0];    end
        end
      end
    end
  end

  assign bl_low   = low_set(bl_q);
  assign ack_data = (nsr_q[ack_thread] != 8'h00) ? {nsr_q[ack_thread], 8'(pp_q[ack_thread])}
                                                  : {8'h00, cppr_q[ack_thread]};
  assign ctx_word = {nsr_q[ctx_thread], cppr_q[ctx_thread], 8'h00,
                     bl_low[PW] ? 8'hFF : 8'(bl_low[PW-1:0])};

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign notify[t] = nsr_q[t] != 8'h00;

    AST_NSR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      nsr_q[t] == 8'h00 || nsr_q[t] == ST_THR || nsr_q[t] == ST_GRP); // R4
    AST_PRESENT_ADMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      nsr_q[t] != 8'h00 |-> 8'(pp_q[t]) < cppr_q[t]); // R3
    AST_ACK_SETS_CPPR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && ack_thread == TW'(t) && nsr_q[t] != 8'h00
      |=> nsr_q[t] == 8'h00 && cppr_q[t] == 8'($past(pp_q[t]))); // R8
    AST_CPPR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cppr_we && cppr_thread == TW'(t) && !(ack_req && ack_thread == TW'(t) && nsr_q[t] != 8'h00)
      |=> cppr_q[t] == $past(cppr_data)); // R7
  end
endmodule

// File: tb/sim_grp_irq_presenter.sv
`timescale 1ns/1ps
module sim_grp_irq_presenter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_valid = 0, irq_group = 0, cppr_we = 0, ack_req = 0;
  logic [1:0] irq_thread = 0, cppr_thread = 0, ack_thread = 0, ctx_thread = 0;
  logic [2:0] irq_prio = 0;
  logic [7:0] cppr_data = 0;
  logic [15:0] ack_data;
  logic [31:0] ctx_word;
  logic [3:0] notify;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grp_irq_presenter u0 (.*);

  // {cppr t0, t1, t2, t3, group, target, prio, presented, exp thread, pad}
  localparam logic [43:0] VEC [8] = '{
    {8'hFF,8'hFF,8'hFF,8'hFF, 1'b1,2'd0,3'd5, 1'b1,2'd0, 3'd0},
    {8'h03,8'hFF,8'hFF,8'hFF, 1'b1,2'd0,3'd6, 1'b1,2'd1, 3'd0},
    {8'h02,8'h02,8'h07,8'h01, 1'b1,2'd0,3'd4, 1'b1,2'd2, 3'd0},
    {8'h02,8'h02,8'h02,8'h02, 1'b1,2'd0,3'd3, 1'b0,2'd0, 3'd0},
    {8'hFF,8'hFF,8'hFF,8'hFF, 1'b0,2'd2,3'd0, 1'b1,2'd2, 3'd0},
    {8'h01,8'hFF,8'hFF,8'hFF, 1'b0,2'd0,3'd1, 1'b0,2'd0, 3'd0},
    {8'h00,8'h00,8'h00,8'h01, 1'b1,2'd0,3'd0, 1'b1,2'd3, 3'd0},
    {8'h05,8'h05,8'h05,8'h05, 1'b1,2'd0,3'd5, 1'b0,2'd0, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_cppr(input logic [1:0] t, input logic [7:0] v);
    cppr_we = 1; cppr_thread = t; cppr_data = v;
    @(negedge clk);
    cppr_we = 0;
  endtask

  task automatic raise(input logic g, input logic [1:0] t, input logic [2:0] p);
    irq_valid = 1; irq_group = g; irq_thread = t; irq_prio = p;
    @(negedge clk);
    irq_valid = 0;
  endtask

  task automatic do_ack(input logic [1:0] t, output logic [15:0] d);
    ack_req = 1; ack_thread = t;
    #1 d = ack_data;
    @(negedge clk);
    ack_req = 0;
  endtask

  task automatic rd_ctx(input logic [1:0] t, output logic [31:0] w);
    ctx_thread = t;
    #1 w = ctx_word;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [15:0] d;
    @(negedge clk);
    do_reset();
    // R1 reset state
    for (int t = 0; t < 4; t++) begin
      rd_ctx(2'(t), w);
      chk("R1", w, 32'h00FF00FF);
    end
    chk("R1", 32'(notify), 32'h0);
    // R10 ack with nothing presented
    do_ack(2'd2, d);
    chk("R10", 32'(d), 32'h000000FF);
    rd_ctx(2'd2, w);
    chk("R10", w, 32'h00FF00FF);

    // vector table: R3 R4 R5 R6 R8
    for (int i = 0; i < 8; i++) begin
      logic [43:0] v;
      logic g, pr;
      logic [1:0] tg, th;
      logic [2:0] p;
      logic [7:0] nx, lx;
      string tag;
      v = VEC[i];
      g = v[11]; tg = v[10:9]; p = v[8:6]; pr = v[5]; th = v[4:3];
      tag = g ? (pr ? "R4" : "R6") : "R5";
      do_reset();
      for (int t = 0; t < 4; t++)
        if (v[43-8*t -: 8] != 8'hFF) wr_cppr(2'(t), v[43-8*t -: 8]);
      raise(g, tg, p);
      lx = (g && !pr) ? {5'b0, p} : 8'hFF;
      for (int t = 0; t < 4; t++) begin
        nx = (pr && th == 2'(t)) ? (g ? 8'h82 : 8'h80) : 8'h00;
        rd_ctx(2'(t), w);
        chk(tag, w, {nx, v[43-8*t -: 8], 8'h00, lx});
      end
      if (pr) begin
        do_ack(th, d);
        chk("R8", 32'(d), {16'h0, (g ? 8'h82 : 8'h80), 5'b0, p});
        rd_ctx(th, w);
        chk("R8", w, {8'h00, 5'b0, p, 16'h00FF});
      end
    end

    // R6 R7 R8 backlog then relax one thread
    do_reset();
    for (int t = 0; t < 4; t++) wr_cppr(2'(t), 8'h02);
    raise(1'b1, 2'd0, 3'd3);
    chk("R6", 32'(notify), 32'h0);
    rd_ctx(2'd1, w);
    chk("R2", w, 32'h00020003);
    wr_cppr(2'd3, 8'h04);
    rd_ctx(2'd3, w);
    chk("R7", w, 32'h820400FF);
    chk("R7", 32'(notify), 32'h8);
    do_ack(2'd3, d);
    chk("R8", 32'(d), 32'h00008203);
    rd_ctx(2'd3, w);
    chk("R8", w, 32'h000300FF);
    wr_cppr(2'd3, 8'hFF);
    rd_ctx(2'd3, w);
    chk("R7", w, 32'h00FF00FF);

    // R5 blocked thread request presented after relax
    do_reset();
    wr_cppr(2'd0, 8'h01);
    raise(1'b0, 2'd0, 3'd1);
    chk("R5", 32'(notify), 32'h0);
    wr_cppr(2'd0, 8'hFF);
    rd_ctx(2'd0, w);
    chk("R5", w, 32'h80FF00FF);
    chk("R5", 32'(notify), 32'h1);

    // R9 withdraw to another thread
    do_reset();
    raise(1'b1, 2'd0, 3'd4);
    rd_ctx(2'd0, w);
    chk("R9", w, 32'h82FF00FF);
    wr_cppr(2'd0, 8'h03);
    rd_ctx(2'd0, w);
    chk("R9", w, 32'h000300FF);
    rd_ctx(2'd1, w);
    chk("R9", w, 32'h82FF00FF);

    // R11 two backlog levels
    do_reset();
    for (int t = 0; t < 4; t++) wr_cppr(2'(t), 8'h00);
    raise(1'b1, 2'd0, 3'd6);
    raise(1'b1, 2'd0, 3'd2);
    rd_ctx(2'd2, w);
    chk("R11", w, 32'h00000002);
    wr_cppr(2'd0, 8'hFF);
    rd_ctx(2'd0, w);
    chk("R11", w, 32'h82FF0006);
    do_ack(2'd0, d);
    chk("R11", 32'(d), 32'h00008202);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule